// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps 64-bit host-side request addresses onto bus-side addresses for an outbound link controller. It holds a bank of programmable windows. Each window has a 64-bit match value, a 64-bit remap value, a 64-bit mask and a 32-bit action word. Every request is compared against all enabled windows in the same cycle. On a hit, the bits selected by the mask are replaced with the remap bits, and the window's action word goes out with the translated address. On a miss, the address passes through unchanged and a single default action word is attached. This gives transparent access for any range that no window claims.

Software programs the bank through a word-wide register port with byte offsets. Downstream logic takes the registered result one cycle after the request and uses the action word to build the outgoing transaction. Windows are power-of-two sized and aligned. The mask has a floor of 64 KiB, because the low 16 mask bits cannot be set.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, every register reads zero, `rsp_valid` is 0, and a request misses with its address unchanged and action 0 (memory type).
- R2: A window is enabled only when bit 0 of its match-low word (byte offset 0x00 in its block) is 1. An enabled window hits when (request AND mask) equals (match AND mask).
- R3: On a hit, `rsp_addr` equals (remap AND mask) OR (request AND NOT mask), using the full 64-bit values.
- R4: Bits 15:0 of every mask-low word (block offset 0x10) are stored and read back as zero, whatever value is written.
- R5: When several enabled windows hit, the lowest-numbered one is used, and `rsp_win` reports its index.
- R6: On a miss, `rsp_hit` is 0, `rsp_win` is 0, `rsp_addr` equals the request, and `rsp_action` equals the default action word at byte offset 0xFC.
- R7: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high, and low otherwise.
- R8: Window n occupies bytes 0x20*n to 0x20*n+0x1F. Its block offsets are 0x00 match-low, 0x04 match-high, 0x08 remap-low, 0x0C remap-high, 0x10 mask-low, 0x14 mask-high and 0x18 action. A read returns the word on `cfg_rdata` one cycle after `cfg_rd_en`. Offset 0x1C of windows 0 to 6 reads zero and ignores writes.
- R9: Writing zero to all seven registers of a window makes it stop hitting.
- R10: A request in the same cycle as a register write is translated with the contents the registers had before that write.
- R11: The 32-bit action word is returned unaltered. Examples are the type field at bits 3:0 (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message) and traffic class at bits 10:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register byte address (word aligned) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 64 | Host-side request address |
| rsp_valid | output | 1 | Registered result valid |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the winning window (0 on miss) |
| rsp_addr | output | 64 | Translated address |
| rsp_action | output | 32 | Action word of the winning window or the default |

## Verification
The two functions that can fall in the same cycle are a register write and a translation request. The bench drives a write that disables a window on the same edge as a request that this window would claim. The response is judged correct only if it still reports a hit on the old window. The bench then sends a second request and expects it to miss or move to another window. Overlapping windows with the same request are also used to judge the priority choice, and random window layouts are compared against a bench model on every request.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int ADDR_W = 64;
  localparam int WORD_W = 32;

  // byte offsets inside one window block
  localparam int OFF_MATCH_LO = 'h00;
  localparam int OFF_MATCH_HI = 'h04;
  localparam int OFF_REMAP_LO = 'h08;
  localparam int OFF_REMAP_HI = 'h0C;
  localparam int OFF_MASK_LO  = 'h10;
  localparam int OFF_MASK_HI  = 'h14;
  localparam int OFF_ACTION   = 'h18;

  // action type encodings carried in bits 3:0
  typedef enum logic [3:0] {
    ACT_MEM   = 4'h0,
    ACT_IO    = 4'h4,
    ACT_CFG0  = 4'h8,
    ACT_CFG1  = 4'h9,
    ACT_MSG   = 4'hC
  } act_kind_e;

  function automatic logic [ADDR_W-1:0] remap_addr(
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] remap,
    input logic [ADDR_W-1:0] mask);
    return (remap & mask) | (addr & ~mask);
  endfunction
endpackage

// File: rtl/obwin_regfile.sv
module obwin_regfile
  import obwin_pkg::*;
#(
  parameter int NUM_WIN     = 8,
  parameter int WIN_STRIDE  = 32,
  parameter int FLOOR_BITS  = 16,
  parameter int CFG_AW      = $clog2(NUM_WIN*WIN_STRIDE)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [CFG_AW-1:0]                addr,
  input  logic [WORD_W-1:0]                wdata,
  output logic [WORD_W-1:0]                rdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   match_q,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   remap_q,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   mask_q,
  output logic [NUM_WIN-1:0][WORD_W-1:0]   action_q,
  output logic [WORD_W-1:0]                dflt_q
);
  localparam int SLOT_AW   = $clog2(WIN_STRIDE);
  localparam int IDX_W     = CFG_AW - SLOT_AW;
  localparam int DFLT_BYTE = NUM_WIN*WIN_STRIDE - 4;
  localparam logic [WORD_W-1:0] LO_KEEP = ~((WORD_W'(1) << FLOOR_BITS) - WORD_W'(1));

  logic [IDX_W-1:0]   win_sel;
  logic [SLOT_AW-1:0] slot;
  logic               aligned;
  logic               is_dflt;
  logic [WORD_W-1:0]  rd_word;

  assign win_sel = addr[CFG_AW-1:SLOT_AW];
  assign slot    = addr[SLOT_AW-1:0];
  assign aligned = (addr[1:0] == 2'b00);
  assign is_dflt = (addr == CFG_AW'(DFLT_BYTE));

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q  <= '0;
      remap_q  <= '0;
      mask_q   <= '0;
      action_q <= '0;
    end else if (wr_en && aligned && !is_dflt) begin
      case (slot)
        SLOT_AW'(OFF_MATCH_LO): match_q[win_sel][31:0]  <= wdata;
        SLOT_AW'(OFF_MATCH_HI): match_q[win_sel][63:32] <= wdata;
        SLOT_AW'(OFF_REMAP_LO): remap_q[win_sel][31:0]  <= wdata;
        SLOT_AW'(OFF_REMAP_HI): remap_q[win_sel][63:32] <= wdata;
        SLOT_AW'(OFF_MASK_LO):  mask_q[win_sel][31:0]   <= wdata & LO_KEEP;
        SLOT_AW'(OFF_MASK_HI):  mask_q[win_sel][63:32]  <= wdata;
        SLOT_AW'(OFF_ACTION):   action_q[win_sel]       <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      dflt_q <= '0;
    else if (wr_en && is_dflt)
      dflt_q <= wdata;
  end

  always_comb begin
    rd_word = '0;
    if (!aligned) begin
      rd_word = '0;
    end else if (is_dflt) begin
      rd_word = dflt_q;
    end else begin
      case (slot)
        SLOT_AW'(OFF_MATCH_LO): rd_word = match_q[win_sel][31:0];
        SLOT_AW'(OFF_MATCH_HI): rd_word = match_q[win_sel][63:32];
        SLOT_AW'(OFF_REMAP_LO): rd_word = remap_q[win_sel][31:0];
        SLOT_AW'(OFF_REMAP_HI): rd_word = remap_q[win_sel][63:32];
        SLOT_AW'(OFF_MASK_LO):  rd_word = mask_q[win_sel][31:0];
        SLOT_AW'(OFF_MASK_HI):  rd_word = mask_q[win_sel][63:32];
        SLOT_AW'(OFF_ACTION):   rd_word = action_q[win_sel];
        default:                rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_word;
  end
endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  match_q,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  mask_q,
  output logic [NUM_WIN-1:0]              hit
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic enabled;
    logic same;
    assign enabled = match_q[w][0];
    assign same    = ((req_addr & mask_q[w]) == (match_q[w] & mask_q[w]));
    assign hit[w]  = enabled && same;
  end
endmodule

// File: rtl/obwin_select.sv
module obwin_select
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [NUM_WIN-1:0]               hit,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   remap_q,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   mask_q,
  input  logic [NUM_WIN-1:0][WORD_W-1:0]   action_q,
  input  logic [WORD_W-1:0]                dflt_q,
  output logic                             rsp_valid,
  output logic                             rsp_hit,
  output logic [IDX_W-1:0]                 rsp_win,
  output logic [ADDR_W-1:0]                rsp_addr,
  output logic [WORD_W-1:0]                rsp_action
);
  logic [IDX_W-1:0]  sel_idx;
  logic              any_hit;
  logic [ADDR_W-1:0] next_addr;
  logic [WORD_W-1:0] next_action;

  // scan from the top so that the lowest index is the last assignment
  always_comb begin
    sel_idx = '0;
    any_hit = 1'b0;
    for (int i = NUM_WIN-1; i >= 0; i--) begin
      if (hit[i]) begin
        sel_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_hit) begin
      next_addr   = remap_addr(req_addr, remap_q[sel_idx], mask_q[sel_idx]);
      next_action = action_q[sel_idx];
    end else begin
      next_addr   = req_addr;
      next_action = dflt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_win    <= '0;
      rsp_addr   <= '0;
      rsp_action <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit    <= any_hit;
        rsp_win    <= sel_idx;
        rsp_addr   <= next_addr;
        rsp_action <= next_action;
      end
    end
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int WIN_STRIDE = 32,
  parameter int FLOOR_BITS = 16,
  parameter int CFG_AW     = $clog2(NUM_WIN*WIN_STRIDE),
  parameter int IDX_W      = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic               cfg_rd_en,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic [63:0]        req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [IDX_W-1:0]   rsp_win,
  output logic [63:0]        rsp_addr,
  output logic [31:0]        rsp_action
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] match_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] remap_q;
  logic [NUM_WIN-1:0][ADDR_W-1:0] mask_q;
  logic [NUM_WIN-1:0][WORD_W-1:0] action_q;
  logic [WORD_W-1:0]              dflt_q;
  logic [NUM_WIN-1:0]             hit;

  obwin_regfile #(
    .NUM_WIN(NUM_WIN), .WIN_STRIDE(WIN_STRIDE),
    .FLOOR_BITS(FLOOR_BITS), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .rd_en(cfg_rd_en),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .match_q(match_q), .remap_q(remap_q), .mask_q(mask_q),
    .action_q(action_q), .dflt_q(dflt_q)
  );

  obwin_match #(.NUM_WIN(NUM_WIN)) u_match (
    .req_addr(req_addr), .match_q(match_q), .mask_q(mask_q), .hit(hit)
  );

  obwin_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .hit(hit),
    .remap_q(remap_q), .mask_q(mask_q), .action_q(action_q), .dflt_q(dflt_q),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_addr(rsp_addr), .rsp_action(rsp_action)
  );
endmodule

// File: rtl/obwin_xlate_chk.sv
module obwin_xlate_chk #(
  parameter int NUM_WIN    = 8,
  parameter int WIN_STRIDE = 32,
  parameter int FLOOR_BITS = 16,
  parameter int CFG_AW     = 8,
  parameter int IDX_W      = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_rd_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              req_valid,
  input logic [63:0]       req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [IDX_W-1:0]  rsp_win,
  input logic [63:0]       rsp_addr
);
  localparam int SLOT_AW   = $clog2(WIN_STRIDE);
  localparam int DFLT_BYTE = NUM_WIN*WIN_STRIDE - 4;

  // R1: idle output right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rsp_valid) else $error("R1 rsp_valid after reset");

  // R7: one-cycle latency
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid) else $error("R7 missing response");

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid) else $error("R7 spurious response");

  // R3: bits below the mask floor always come from the request
  a_r3_floor_kept: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_addr[FLOOR_BITS-1:0] == $past(req_addr[FLOOR_BITS-1:0]))
    else $error("R3 low bits altered");

  // R6: miss passes the address through and reports window 0
  a_r6_miss_pass: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == $past(req_addr) && rsp_win == '0))
    else $error("R6 miss altered address");

  // R4: mask-low never reads back bits under the floor
  a_r4_mask_floor: assert property (@(posedge clk) disable iff (rst)
    (cfg_rd_en && cfg_addr != CFG_AW'(DFLT_BYTE) &&
     cfg_addr[SLOT_AW-1:0] == SLOT_AW'(16)) |=> cfg_rdata[FLOOR_BITS-1:0] == '0)
    else $error("R4 mask floor bits set");
endmodule

bind obwin_xlate obwin_xlate_chk #(
  .NUM_WIN(NUM_WIN), .WIN_STRIDE(WIN_STRIDE), .FLOOR_BITS(FLOOR_BITS),
  .CFG_AW(CFG_AW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
  .rsp_addr(rsp_addr)
);

// File: tb/obwin_xlate_bench.sv
`timescale 1ns/1ps
module obwin_xlate_bench;
  import obwin_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_rd_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_win;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_action;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  obwin_xlate u_obwin_xlate (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
    .rsp_action(rsp_action)
  );

  // bench model of the register bank
  logic [63:0] m_match [8];
  logic [63:0] m_remap [8];
  logic [63:0] m_mask  [8];
  logic [31:0] m_act   [8];
  logic [31:0] m_dflt;

  function automatic void model_reset();
    for (int i = 0; i < 8; i++) begin
      m_match[i] = '0; m_remap[i] = '0; m_mask[i] = '0; m_act[i] = '0;
    end
    m_dflt = '0;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    int w;
    w = int'(a[7:5]);
    if (a == 8'hFC) m_dflt = d;
    else case (a[4:0])
      5'h00: m_match[w][31:0]  = d;
      5'h04: m_match[w][63:32] = d;
      5'h08: m_remap[w][31:0]  = d;
      5'h0C: m_remap[w][63:32] = d;
      5'h10: m_mask[w][31:0]   = d & 32'hFFFF_0000;
      5'h14: m_mask[w][63:32]  = d;
      5'h18: m_act[w]          = d;
      default: ;
    endcase
  endfunction

  function automatic void predict(input logic [63:0] a, output logic hit,
      output logic [2:0] win, output logic [63:0] xa, output logic [31:0] act);
    hit = 1'b0; win = '0; xa = a; act = m_dflt;
    for (int i = 0; i < 8; i++) begin
      if (!hit && m_match[i][0] && ((a & m_mask[i]) == (m_match[i] & m_mask[i]))) begin
        hit = 1'b1; win = 3'(i);
        xa = (m_remap[i] & m_mask[i]) | (a & ~m_mask[i]);
        act = m_act[i];
      end
    end
  endfunction

  function automatic void check(input bit ok, input string tag,
      input logic [63:0] actual, input logic [63:0] expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endfunction

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic cfg_rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    check(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic set_win(input int w, input logic [63:0] mt, input logic [63:0] rm,
      input logic [63:0] mk, input logic [31:0] ac);
    logic [7:0] b;
    b = 8'(w * 32);
    cfg_wr(b + 8'h00, mt[31:0]);  cfg_wr(b + 8'h04, mt[63:32]);
    cfg_wr(b + 8'h08, rm[31:0]);  cfg_wr(b + 8'h0C, rm[63:32]);
    cfg_wr(b + 8'h10, mk[31:0]);  cfg_wr(b + 8'h14, mk[63:32]);
    cfg_wr(b + 8'h18, ac);
  endtask

  task automatic compare_rsp(input string tag, input logic eh, input logic [2:0] ew,
      input logic [63:0] ea, input logic [31:0] ec);
    bit ok;
    ok = rsp_valid && rsp_hit == eh && rsp_win == ew && rsp_addr == ea && rsp_action == ec;
    check(ok, tag, rsp_addr, ea);
    if (!ok)
      $display("  detail %s hit=%0b/%0b win=%0d/%0d act=%h/%h valid=%0b",
               tag, rsp_hit, eh, rsp_win, ew, rsp_action, ec, rsp_valid);
  endtask

  task automatic send_chk(input logic [63:0] a, input string tag);
    logic eh; logic [2:0] ew; logic [63:0] ea; logic [31:0] ec;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    predict(a, eh, ew, ea, ec);
    @(negedge clk);
    req_valid = 1'b0;
    compare_rsp(tag, eh, ew, ea, ec);
  endtask

  function automatic logic [63:0] rand64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic eh; logic [2:0] ew; logic [63:0] ea; logic [31:0] ec;
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
    cfg_rd_chk(8'hFC, 32'h0, "R1 default action reset");
    cfg_rd_chk(8'h60, 32'h0, "R1 match-low reset");
    send_chk(64'h1234_5678_9ABC_DEF0, "R1 pass-through after reset");
    check(rsp_action == 32'h0, "R1 action memory after reset", 64'(rsp_action), 64'd0);

    // R7: valid drops one cycle after the request ends
    @(negedge clk);
    check(rsp_valid == 1'b0, "R7 valid drops", 64'(rsp_valid), 64'd0);

    // R8/R4/R11: window 2 with I/O type, traffic class 1, attribute enable
    set_win(2, 64'h0000_0040_8000_0001, 64'h0000_0000_2000_0000,
            64'hFFFF_FFFF_F000_FFFF, 32'h0000_0900 | 32'(ACT_IO));
    cfg_rd_chk(8'h40, 32'h8000_0001, "R8 match-low readback");
    cfg_rd_chk(8'h44, 32'h0000_0040, "R8 match-high readback");
    cfg_rd_chk(8'h48, 32'h2000_0000, "R8 remap-low readback");
    cfg_rd_chk(8'h54, 32'hFFFF_FFFF, "R8 mask-high readback");
    cfg_rd_chk(8'h50, 32'hF000_0000, "R4 mask floor zero");
    cfg_rd_chk(8'h58, 32'h0000_0904, "R11 action readback");

    // R2/R3/R11: hit on window 2
    send_chk(64'h0000_0040_8ABC_1234, "R3 window 2 translate");
    check(rsp_addr == 64'h0000_0000_2ABC_1234, "R3 fixed value", rsp_addr, 64'h0000_0000_2ABC_1234);
    check(rsp_action[3:0] == ACT_IO && rsp_action[10:8] == 3'd1, "R11 action fields",
          64'(rsp_action), 64'h904);

    // R5: overlapping window 5 (larger), window 2 must win inside its range
    set_win(5, 64'h0000_0040_0000_0001, 64'h0000_0100_0000_0000,
            64'hFFFF_FF00_0000_0000, 32'(ACT_CFG1));
    send_chk(64'h0000_0040_8000_0010, "R5 lower window wins");
    send_chk(64'h0000_0040_1234_5678, "R5 only window 5 hits");
    check(rsp_win == 3'd5, "R5 index 5", 64'(rsp_win), 64'd5);
    set_win(0, 64'h0000_0040_8000_0001, 64'h0000_0200_0000_0000,
            64'hFFFF_FFFF_FFFF_0000, 32'(ACT_MSG));
    send_chk(64'h0000_0040_8000_ABCD, "R5 window 0 wins");
    check(rsp_win == 3'd0 && rsp_hit, "R5 index 0", 64'(rsp_win), 64'd0);

    // R6: default action on miss
    cfg_wr(8'hFC, 32'h0000_0010);
    send_chk(64'hFFFF_0000_0000_0042, "R6 miss default action");
    check(rsp_hit == 1'b0 && rsp_action == 32'h10, "R6 miss flags", 64'(rsp_action), 64'h10);

    // R2: window with enable bit clear never hits
    set_win(3, 64'h0000_7000_0000_0000, 64'h0, 64'hFFFF_F000_0000_0000, 32'(ACT_CFG0));
    send_chk(64'h0000_7000_0000_0100, "R2 disabled window misses");

    // R9: zero all of window 0, window 2 takes over
    set_win(0, 64'h0, 64'h0, 64'h0, 32'h0);
    send_chk(64'h0000_0040_8000_ABCD, "R9 zeroed window inert");
    check(rsp_win == 3'd2, "R9 falls to window 2", 64'(rsp_win), 64'd2);

    // R10: write disabling window 2 on the same edge as a request into it
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 8'h40; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 64'h0000_0040_8000_0020;
    predict(req_addr, eh, ew, ea, ec);
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    model_write(8'h40, 32'h0);
    compare_rsp("R10 old contents used", eh, ew, ea, ec);
    check(ew == 3'd2, "R10 expected window 2", 64'(ew), 64'd2);
    send_chk(64'h0000_0040_8000_0020, "R10 new contents next request");
    check(rsp_win == 3'd5, "R10 moved to window 5", 64'(rsp_win), 64'd5);

    // R8: unused slot 0x1C ignored, default unaffected
    cfg_wr(8'h1C, 32'hDEAD_BEEF);
    cfg_rd_chk(8'h1C, 32'h0, "R8 unused slot reads zero");
    cfg_rd_chk(8'hFC, 32'h0000_0010, "R8 default intact");

    // random phase, R3/R5/R6 against the model
    for (int it = 0; it < 400; it++) begin
      if (it % 20 == 0) begin
        int w, k;
        logic [63:0] mk, mt;
        w = int'($urandom % 8);
        k = 16 + int'($urandom % 24);
        mk = ~64'h0 << k;
        mt = (rand64() & mk) | 64'(($urandom % 4) != 0);
        set_win(w, mt, rand64() & mk, mk, $urandom);
      end
      if ($urandom % 2 == 0) begin
        int w;
        w = int'($urandom % 8);
        send_chk((m_match[w] & m_mask[w]) | (rand64() & ~m_mask[w]), "R3 random near window");
      end else begin
        send_chk(rand64(), "R6 random address");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule